// File: doc/BRIEF.md
# Two-Action Learning Automaton

This block holds one learned yes/no decision for a single input literal: whether that literal is included in a clause or left out of it. The decision is stored as a position on a saturating state line of 2N states. The lower half of the line means exclude and the upper half means include. A team of these blocks, one per literal, together supplies the exclude vector of a clause.

Each clock cycle the block can receive one feedback pulse. A reward pushes the state further into the half it already occupies, and stops at the outer ends. A penalty pulls the state toward the middle. Two penalties in a row cross the boundary, and one of them flips the decision.

The action bit and the state are both registered. They change in the cycle after the clock edge that samples the pulse. The rules that decide when to reward or penalise, and any random source, belong to the surrounding logic.

Top module: `two_action_automaton`

## Requirements
- R1: A synchronous active-low reset loads state N with action 0 (exclude) when START_INCLUDE is 0, and state N+1 with action 1 (include) when START_INCLUDE is 1. Reset takes priority over any feedback input.
- R2: `action_o` is 0 (exclude) whenever `state_o` is in 1..N, and 1 (include) whenever it is in N+1..2N.
- R3: A reward alone, while the state is in 2..N, lowers the state by one. A reward alone at state 1 leaves it at 1.
- R4: A reward alone, while the state is in N+1..2N-1, raises the state by one. A reward alone at state 2N leaves it at 2N.
- R5: A penalty alone, while the state is in 1..N, raises the state by one. From state N it moves to N+1, so the action turns from 0 to 1.
- R6: A penalty alone, while the state is in N+1..2N, lowers the state by one. From state N+1 it moves to N, so the action turns from 1 to 0.
- R7: If reward and penalty are both high in the same cycle, the input is illegal. Both pulses are ignored, and the state and action hold.
- R8: If neither reward nor penalty is high, the state and action hold.
- R9: After reset, `state_o` always stays within 1..2N.
- R10: Outputs change only at a clock edge. A pulse sampled at one edge is visible on the outputs after that edge and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| reward_i | input | 1 | Reward pulse for this cycle |
| penalty_i | input | 1 | Penalty pulse for this cycle |
| action_o | output | 1 | Learned action: 1 include, 0 exclude |
| state_o | output | $clog2(2N+1) | Current state, 1..2N |

## Verification
Reward and penalty are the two functions that can fall in the same cycle. The stimulus table drives both high together at the top end state and again at the lower middle state, where a penalty alone would move the state. Each time, the bench expects the state and action on the next sample to equal what they were before. A paired assertion in the RTL expects the state to be stable after any such cycle.

// File: rtl/ta_pkg.sv
// Shared types for the two-action learning automaton.
package ta_pkg;

    // Decoded feedback for one cycle.
    typedef enum logic [1:0] {
        FB_NONE     = 2'b00,
        FB_REWARD   = 2'b01,
        FB_PENALTY  = 2'b10,
        FB_CONFLICT = 2'b11
    } fb_e;

endpackage

// File: rtl/ta_fb_decode.sv
// Feedback decoder.
// Turns the two raw pulse inputs into one feedback kind.
// Assumes the inputs are synchronous to the automaton clock.
module ta_fb_decode
    import ta_pkg::*;
(
    input  logic reward_i,
    input  logic penalty_i,
    output fb_e  fb_o
);

    // Classify the pair of pulses; both high is marked as a conflict.
    always_comb begin
        unique case ({penalty_i, reward_i})
            2'b01:   fb_o = FB_REWARD;
            2'b10:   fb_o = FB_PENALTY;
            2'b11:   fb_o = FB_CONFLICT;
            default: fb_o = FB_NONE;
        endcase
    end

endmodule

// File: rtl/ta_step.sv
// Next-state function of the automaton.
// States run from 1 to 2*HALF. A reward moves the state away from the
// midpoint and saturates at the ends. A penalty moves it toward the
// midpoint and across it. Conflict and none both hold the state.
// Assumes state_i is already in range.
module ta_step
    import ta_pkg::*;
#(
    parameter int HALF = 4,
    parameter int W    = $clog2(2 * HALF + 1)
) (
    input  logic [W-1:0] state_i,
    input  fb_e          fb_i,
    output logic [W-1:0] state_o
);

    localparam logic [W-1:0] ONE = W'(1);
    localparam logic [W-1:0] MID = W'(HALF);
    localparam logic [W-1:0] TOP = W'(2 * HALF);

    logic lower_half;
    assign lower_half = (state_i <= MID);

    // Apply one step of reinforcement to the current state.
    always_comb begin
        state_o = state_i;
        unique case (fb_i)
            FB_REWARD: begin
                if (lower_half) begin
                    if (state_i != ONE) state_o = state_i - ONE;
                end else begin
                    if (state_i != TOP) state_o = state_i + ONE;
                end
            end
            FB_PENALTY: begin
                if (lower_half) state_o = state_i + ONE;
                else            state_o = state_i - ONE;
            end
            default: state_o = state_i;
        endcase
    end

endmodule

// File: rtl/ta_action_dec.sv
// Action decoder: include when the state lies above the midpoint.
// Assumes the state is in 1..2*HALF.
module ta_action_dec #(
    parameter int HALF = 4,
    parameter int W    = $clog2(2 * HALF + 1)
) (
    input  logic [W-1:0] state_i,
    output logic         include_o
);

    localparam logic [W-1:0] MID = W'(HALF);

    // Threshold compare against the midpoint.
    always_comb include_o = (state_i > MID);

endmodule

// File: rtl/two_action_automaton.sv
// Two-action learning automaton, top level.
// Holds a saturating state line of 2*HALF states and a registered
// include/exclude action. The feedback pulses are sampled at the rising
// edge. The state and action both update at that edge.
// Assumes at most one pulse per cycle; a double pulse is ignored.
module two_action_automaton
    import ta_pkg::*;
#(
    parameter int HALF          = 4,
    parameter bit START_INCLUDE = 1'b0,
    localparam int W            = $clog2(2 * HALF + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         reward_i,
    input  logic         penalty_i,
    output logic         action_o,
    output logic [W-1:0] state_o
);

    localparam logic [W-1:0] MID       = W'(HALF);
    localparam logic [W-1:0] MID_UP    = W'(HALF + 1);
    localparam logic [W-1:0] TOP       = W'(2 * HALF);
    localparam logic [W-1:0] ONE       = W'(1);
    localparam logic [W-1:0] RST_STATE = START_INCLUDE ? MID_UP : MID;

    fb_e          fb;
    logic [W-1:0] state_q, state_d;
    logic         action_q, include_d;

    ta_fb_decode u_dec (
        .reward_i  (reward_i),
        .penalty_i (penalty_i),
        .fb_o      (fb)
    );

    ta_step #(.HALF(HALF), .W(W)) u_step (
        .state_i (state_q),
        .fb_i    (fb),
        .state_o (state_d)
    );

    ta_action_dec #(.HALF(HALF), .W(W)) u_act (
        .state_i   (state_d),
        .include_o (include_d)
    );

    // State and action registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= RST_STATE;
            action_q <= START_INCLUDE;
        end else begin
            state_q  <= state_d;
            action_q <= include_d;
        end
    end

    assign state_o  = state_q;
    assign action_o = action_q;

    // Assertions kept next to the registers they guard.
    assert_state_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q >= ONE) && (state_q <= TOP));

    assert_action_threshold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        action_q == (state_q > MID));

    assert_conflict_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reward_i && penalty_i) |=> $stable(state_q));

    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!reward_i && !penalty_i) |=> $stable(state_q));

    assert_floor_sat_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reward_i && !penalty_i && state_q == ONE) |=> (state_q == ONE));

    assert_ceiling_sat_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reward_i && !penalty_i && state_q == TOP) |=> (state_q == TOP));

    assert_cross_up_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (penalty_i && !reward_i && state_q == MID) |=> (state_q == MID_UP && action_q));

    assert_cross_down_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (penalty_i && !reward_i && state_q == MID_UP) |=> (state_q == MID && !action_q));

endmodule

// File: tb/sim_two_action_automaton.sv
module sim_two_action_automaton;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 4;
    localparam int W          = $clog2(2 * HALF + 1);
    localparam int NVEC       = 22;

    // Vector fields: [6] reward, [5] penalty, [4:1] expected state, [0] expected action.
    localparam logic [6:0] VEC [NVEC] = '{
        {1'b0, 1'b1, 4'd5, 1'b1},  // R5 cross up
        {1'b0, 1'b1, 4'd4, 1'b0},  // R6 cross down
        {1'b1, 1'b0, 4'd3, 1'b0},  // R3
        {1'b1, 1'b0, 4'd2, 1'b0},  // R3
        {1'b1, 1'b0, 4'd1, 1'b0},  // R3
        {1'b1, 1'b0, 4'd1, 1'b0},  // R3 floor
        {1'b0, 1'b1, 4'd2, 1'b0},  // R5
        {1'b0, 1'b1, 4'd3, 1'b0},  // R5
        {1'b0, 1'b1, 4'd4, 1'b0},  // R5
        {1'b0, 1'b1, 4'd5, 1'b1},  // R5
        {1'b1, 1'b0, 4'd6, 1'b1},  // R4
        {1'b1, 1'b0, 4'd7, 1'b1},  // R4
        {1'b1, 1'b0, 4'd8, 1'b1},  // R4
        {1'b1, 1'b0, 4'd8, 1'b1},  // R4 ceiling
        {1'b1, 1'b1, 4'd8, 1'b1},  // R7
        {1'b0, 1'b0, 4'd8, 1'b1},  // R8
        {1'b0, 1'b1, 4'd7, 1'b1},  // R6
        {1'b0, 1'b1, 4'd6, 1'b1},  // R6
        {1'b0, 1'b1, 4'd5, 1'b1},  // R6
        {1'b0, 1'b1, 4'd4, 1'b0},  // R6
        {1'b1, 1'b1, 4'd4, 1'b0},  // R7
        {1'b0, 1'b0, 4'd4, 1'b0}   // R8
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         reward = 1'b0;
    logic         penalty = 1'b0;
    logic         action0, action1;
    logic [W-1:0] state0, state1;

    int  errors = 0;
    int  checks = 0;
    bit  done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    two_action_automaton #(.HALF(HALF), .START_INCLUDE(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .reward_i(reward), .penalty_i(penalty),
        .action_o(action0), .state_o(state0)
    );

    two_action_automaton #(.HALF(HALF), .START_INCLUDE(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .reward_i(reward), .penalty_i(penalty),
        .action_o(action1), .state_o(state1)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset state", int'(state0), HALF);
        chk("R1 reset action", int'(action0), 0);
        chk("R1 reset state include-start", int'(state1), HALF + 1);
        chk("R1 reset action include-start", int'(action1), 1);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            reward  = VEC[i][6];
            penalty = VEC[i][5];
            @(negedge clk);
            chk($sformatf("R2-R8 vector %0d state", i), int'(state0), int'(VEC[i][4:1]));
            chk($sformatf("R2 vector %0d action", i), int'(action0), int'(VEC[i][0]));
            chk("R9 range", int'(state0 >= 1 && state0 <= 2 * HALF), 1);
        end

        // R10: outputs stay put until the edge samples the pulse.
        reward = 1'b0; penalty = 1'b1;
        #1;
        chk("R10 no change before edge", int'(state0), 4);
        @(negedge clk);
        chk("R10 change after edge", int'(state0), 5);
        chk("R10 action after edge", int'(action0), 1);

        // R1: reset wins over a pulse held during reset.
        rst_n = 1'b0; reward = 1'b1; penalty = 1'b0;
        @(negedge clk);
        chk("R1 reset over reward state", int'(state0), HALF);
        chk("R1 reset over reward action", int'(action0), 0);
        chk("R1 reset over reward include-start", int'(state1), HALF + 1);
        rst_n = 1'b1; reward = 1'b0;
        @(negedge clk);
        chk("R8 hold after reset", int'(state0), HALF);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule